// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns a small set of external interrupt pins into interrupt requests for a CPU core. Each pin passes through a two-stage synchronizer. The synchronized sample and the one from the cycle before are compared to find edges. A per-pin trigger select then decides which events count: a falling edge, a rising edge, either edge, or bypass. In bypass mode an extra bit chooses between a falling edge and a sustained low level.

Every pin owns two flags that are cleared independently. The status flag records that an edge event happened and only software clears it. The request flag is what the core polls. It is cleared when the core acknowledges the vector for that pin, or by software. A request leaves the block only while its node enable and the global enable are both set.

Configuration, enables and flags sit behind a simple register port. Writes take effect on the next clock edge, and reads are combinational from the address. The acknowledge input carries the index of the pin being vectored.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: After reset all registers read zero and no irq output is active. A zero configuration means falling-edge mode, and the pin history resets high.
- R2: Trigger select 00 (bits [3i+1:3i] of register 0) sets both the request and status flag of pin i on a falling edge only. The flag is visible after the third rising clock edge that follows the pin change, and not after the second.
- R3: Trigger select 01 sets both flags on a rising edge only, with the R2 latency.
- R4: Trigger select 10 sets both flags on either edge, with the R2 latency.
- R5: Trigger select 11 with bypass level bit 0 (bit 3i+2 of register 0) sets both the request and status flag on a falling edge only, with the R2 latency.
- R6: Trigger select 11 with bypass level bit 1 sets the request flag once the pin has been low for two consecutive synchronized samples. The flag becomes visible after the fourth rising edge. It sets again while the low persists, and a one-cycle low pulse sets nothing. The status flag is never set in this mode.
- R7: An acknowledge with index i clears request bit i only. Status flags and the other request bits are unchanged.
- R8: A write to register 2 (status) clears each bit whose written value is 0 and leaves bits written with 1 unchanged. It never changes the request flags. Register 3 (request) behaves the same way and leaves status unchanged.
- R9: irq_o[i] is high exactly when request bit i, node enable i (register 1, bit i) and the global enable (register 1, bit DATA_W-1) are all set. Register 1 reads back as written.
- R10: When a hardware set and a clear (software write or acknowledge) reach the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_IN | External interrupt pins (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 config, 1 enables, 2 status, 3 request |
| wr_data_i | input | DATA_W | Write data (DATA_W = 3*N_IN) |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Combinational read data |
| ack_i | input | 1 | Vector acknowledge strobe |
| ack_id_i | input | IDW | Index of the acknowledged pin |
| irq_o | output | N_IN | Gated interrupt requests to the core |

## Verification
For every pin, the bench sweeps each trigger mode against a rising and a falling transition. The expected flag pair is computed from the mode. This separates modes that react to the same edge from modes that must ignore it, and it separates the status behaviour of bypass-falling from bypass-level. Each case is sampled one cycle before and at the expected latency, so an extra or missing synchronizer stage is caught. A one-cycle low pulse against a held low level checks the two-sample qualification. Clears that collide with an arriving event check the set-over-clear ordering. A full sweep of the three enable bits checks the output gating.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_FALL   = 2'b00,
    TRIG_RISE   = 2'b01,
    TRIG_BOTH   = 2'b10,
    TRIG_BYPASS = 2'b11
  } trig_sel_e;

  // Per-pin configuration field, 3 bits: level select above trigger select
  typedef struct packed {
    logic      lvl;
    trig_sel_e sel;
  } pin_cfg_t;

  localparam int unsigned CFG_BITS = 3;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_REQ  = 2'd3;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned N_IN   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] pin_i,
  output logic [N_IN-1:0] cur_o,
  output logic [N_IN-1:0] prev_o
);

  logic [N_IN-1:0] chain [STAGES];
  logic [N_IN-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
      prev_q <= '1;
    end else begin
      chain[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign cur_o  = chain[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_IN  = 2,
  localparam int unsigned CW   = CFG_BITS * N_IN
) (
  input  logic [CW-1:0]   cfg_i,
  input  logic [N_IN-1:0] cur_i,
  input  logic [N_IN-1:0] prev_i,
  output logic [N_IN-1:0] set_req_o,
  output logic [N_IN-1:0] set_stat_o
);

  for (genvar i = 0; i < N_IN; i++) begin : g_pin
    pin_cfg_t c;
    logic fall, rise, low2;

    assign c    = pin_cfg_t'(cfg_i[CFG_BITS*i +: CFG_BITS]);
    assign fall =  prev_i[i] & ~cur_i[i];
    assign rise = ~prev_i[i] &  cur_i[i];
    assign low2 = ~prev_i[i] & ~cur_i[i];

    always_comb begin
      set_req_o[i]  = 1'b0;
      set_stat_o[i] = 1'b0;
      unique case (c.sel)
        TRIG_FALL: begin
          set_req_o[i]  = fall;
          set_stat_o[i] = fall;
        end
        TRIG_RISE: begin
          set_req_o[i]  = rise;
          set_stat_o[i] = rise;
        end
        TRIG_BOTH: begin
          set_req_o[i]  = fall | rise;
          set_stat_o[i] = fall | rise;
        end
        TRIG_BYPASS: begin
          if (c.lvl) begin
            set_req_o[i]  = low2;
            set_stat_o[i] = 1'b0;
          end else begin
            set_req_o[i]  = fall;
            set_stat_o[i] = fall;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ext_irq_flag_reg.sv
module ext_irq_flag_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  // set has priority over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;

endmodule

// File: rtl/ext_irq_edge_ctrl.sv
module ext_irq_edge_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_IN     = 2,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned DATA_W  = CFG_BITS * N_IN,
  localparam int unsigned IDW     = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ack_i,
  input  logic [IDW-1:0]    ack_id_i,
  output logic [N_IN-1:0]   irq_o
);

  logic [DATA_W-1:0] cfg_q;
  logic [N_IN-1:0]   node_en_q;
  logic              glb_en_q;
  logic [N_IN-1:0]   cur, prev;
  logic [N_IN-1:0]   set_req, set_stat;
  logic [N_IN-1:0]   clr_req, clr_stat;
  logic [N_IN-1:0]   req_q, stat_q;
  logic [N_IN-1:0]   ack_vec;

  ext_irq_sync #(.N_IN(N_IN), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  ext_irq_detect #(.N_IN(N_IN)) u_detect (
    .cfg_i      (cfg_q),
    .cur_i      (cur),
    .prev_i     (prev),
    .set_req_o  (set_req),
    .set_stat_o (set_stat)
  );

  // Configuration and enable registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      node_en_q <= '0;
      glb_en_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_CFG) cfg_q <= wr_data_i;
      if (wr_addr_i == ADDR_EN) begin
        node_en_q <= wr_data_i[N_IN-1:0];
        glb_en_q  <= wr_data_i[DATA_W-1];
      end
    end
  end

  // Clear sources: write-zero-to-clear and vector acknowledge
  always_comb begin
    ack_vec = '0;
    if (ack_i) ack_vec = N_IN'(1) << ack_id_i;
  end

  assign clr_stat = (wr_en_i && wr_addr_i == ADDR_STAT) ? ~wr_data_i[N_IN-1:0] : '0;
  assign clr_req  = ((wr_en_i && wr_addr_i == ADDR_REQ) ? ~wr_data_i[N_IN-1:0] : '0) | ack_vec;

  ext_irq_flag_reg #(.W(N_IN)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_stat),
    .clr_i  (clr_stat),
    .q_o    (stat_q)
  );

  ext_irq_flag_reg #(.W(N_IN)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_req),
    .clr_i  (clr_req),
    .q_o    (req_q)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CFG:  rd_data_o = cfg_q;
      ADDR_EN: begin
        rd_data_o[N_IN-1:0]   = node_en_q;
        rd_data_o[DATA_W-1]   = glb_en_q;
      end
      ADDR_STAT: rd_data_o[N_IN-1:0] = stat_q;
      ADDR_REQ:  rd_data_o[N_IN-1:0] = req_q;
      default: ;
    endcase
  end

  assign irq_o = req_q & node_en_q & {N_IN{glb_en_q}};

endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_IN = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [1:0]      wr_addr_i,
  input logic            ack_i,
  input logic [N_IN-1:0] set_req,
  input logic [N_IN-1:0] set_stat,
  input logic [N_IN-1:0] req_q,
  input logic [N_IN-1:0] stat_q,
  input logic [N_IN-1:0] node_en_q,
  input logic            glb_en_q,
  input logic [N_IN-1:0] irq_o
);

  assert_stat_sw_clear_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(stat_q) & ~stat_q)) |-> ($past(wr_en_i) && ($past(wr_addr_i) == ADDR_STAT)));

  assert_req_clear_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(req_q) & ~req_q)) |-> ($past(ack_i) || ($past(wr_en_i) && ($past(wr_addr_i) == ADDR_REQ))));

  assert_set_wins_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_req) |=> ((req_q & $past(set_req)) == $past(set_req)));

  assert_set_wins_stat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_stat) |=> ((stat_q & $past(set_stat)) == $past(set_stat)));

  assert_stat_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_stat) |-> ((set_stat & ~set_req) == '0));

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (glb_en_q && ((irq_o & ~node_en_q) == '0) && ((irq_o & ~req_q) == '0)));

endmodule

bind ext_irq_edge_ctrl ext_irq_checker #(.N_IN(N_IN)) u_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .ack_i     (ack_i),
  .set_req   (set_req),
  .set_stat  (set_stat),
  .req_q     (req_q),
  .stat_q    (stat_q),
  .node_en_q (node_en_q),
  .glb_en_q  (glb_en_q),
  .irq_o     (irq_o)
);

// File: tb/test_ext_irq_edge_ctrl.sv
module test_ext_irq_edge_ctrl;

  localparam int N  = 2;
  localparam int DW = 3 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          ack = 1'b0;
  logic          ack_id = 1'b0;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_edge_ctrl #(.N_IN(N)) i_ext_irq_edge_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pin_i     (pins),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .ack_i     (ack),
    .ack_id_i  (ack_id),
    .irq_o     (irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic do_ack(input logic id);
    @(negedge clk);
    ack = 1'b1; ack_id = id;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, d2;
    string tags [5] = '{"R2", "R3", "R4", "R5", "R6"};

    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(2);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 register reset", d, '0);
    end
    check("R1 irq reset", DW'(irq), '0);

    // Sweep: each pin, each mode (4 = bypass low level), each transition
    for (int k = 0; k < N; k++) begin
      for (int m = 0; m < 5; m++) begin
        for (int t = 0; t < 2; t++) begin
          int lat;
          bit hit;
          logic [DW-1:0] cfgw;
          logic [DW-1:0] exp_req, exp_stat;
          if (m == 4 && t == 1) continue;
          cfgw = '0;
          cfgw[3*k +: 3] = (m == 4) ? 3'b111 : 3'(m);
          wr(0, cfgw);
          pins[k] = (t == 1) ? 1'b0 : 1'b1;
          wait_neg(5);
          wr(2, '0);
          wr(3, '0);
          rd(3, d); rd(2, d2);
          check("R8 clear before case", d | d2, '0);
          pins[k] = t[0];
          lat = (m == 4) ? 4 : 3;
          repeat (lat - 1) @(posedge clk);
          @(negedge clk);
          rd(3, d); rd(2, d2);
          check({tags[m], " latency request"}, d, '0);
          check({tags[m], " latency status"}, d2, '0);
          @(posedge clk);
          @(negedge clk);
          case (m)
            0: hit = (t == 0);
            1: hit = (t == 1);
            2: hit = 1'b1;
            default: hit = (t == 0);
          endcase
          exp_req  = hit ? DW'(1) << k : '0;
          exp_stat = (hit && m != 4) ? DW'(1) << k : '0;
          rd(3, d); rd(2, d2);
          check({tags[m], " request flag"}, d, exp_req);
          check({tags[m], " status flag"}, d2, exp_stat);
          pins[k] = 1'b1;
        end
      end
    end

    // R7 / R8: independent clearing
    wr(0, '0);
    wait_neg(4);
    wr(2, '0); wr(3, '0);
    pins = '0;
    wait_neg(4);
    rd(3, d); check("R2 both pins request", d, 6'h3);
    do_ack(1'b0);
    rd(3, d); check("R7 ack clears only its request", d, 6'h2);
    rd(2, d); check("R7 ack leaves status", d, 6'h3);
    wr(2, 6'b000010);
    rd(2, d); check("R8 write-zero clears status bit", d, 6'h2);
    rd(3, d); check("R8 status write leaves request", d, 6'h2);
    wr(3, 6'b000000);
    rd(3, d); check("R8 request write clears", d, '0);
    rd(2, d); check("R8 request write leaves status", d, 6'h2);

    // R9: enable gating sweep
    pins = '1;
    wait_neg(4);
    pins = '0;
    wait_neg(4);
    for (int c = 0; c < 8; c++) begin
      logic [DW-1:0] ew;
      logic [N-1:0] exp_irq;
      ew = '0;
      ew[1:0] = 2'(c);
      ew[DW-1] = c[2];
      wr(1, ew);
      exp_irq = c[2] ? 2'(c) : 2'b00;
      check("R9 irq gating", DW'(irq), DW'(exp_irq));
      rd(1, d); check("R9 enable readback", d, ew);
    end
    wr(1, '0);

    // R6: level qualification
    pins = '1;
    wr(0, 6'b000111);
    wait_neg(4);
    wr(2, '0); wr(3, '0);
    @(negedge clk); pins[0] = 1'b0;
    @(negedge clk); pins[0] = 1'b1;
    wait_neg(6);
    rd(3, d); check("R6 short low pulse ignored", d, '0);
    pins[0] = 1'b0;
    wait_neg(5);
    do_ack(1'b0);
    @(negedge clk);
    rd(3, d); check("R6 held low re-sets request", d & 6'h1, 6'h1);
    rd(2, d); check("R6 level never sets status", d, '0);
    pins[0] = 1'b1;
    wait_neg(3);
    do_ack(1'b0);
    rd(3, d); check("R7 ack after level released", d & 6'h1, '0);

    // R10: set beats same-cycle clear
    wr(0, 6'b000010);
    wait_neg(4);
    wr(2, '0); wr(3, '0);
    pins[0] = 1'b0;
    wait_neg(4);
    pins[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = '0;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2, d); check("R10 status set beats write clear", d & 6'h1, 6'h1);
    wr(2, '0);
    rd(2, d); check("R8 plain status clear", d & 6'h1, '0);
    pins[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    ack = 1'b1; ack_id = 1'b0;
    @(negedge clk);
    ack = 1'b0;
    rd(3, d); check("R10 request set beats ack", d & 6'h1, 6'h1);
    do_ack(1'b0);
    rd(3, d); check("R7 plain ack clears", d & 6'h1, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule